// File: doc/BRIEF.md
# Rank Idle Power-Down and Self-Refresh Controller

This block watches whether a memory rank has work pending and puts it into a low-power state after programmable idle periods. A short idle count, compared against an 8-bit threshold, moves the rank into power-down when the 3-bit mode selects a power-down flavour. A longer 16-bit idle count, honoured only while a self-refresh enable is set, moves the rank into self-refresh, either from the active state or from power-down.

When a transaction becomes pending while the rank is in a low-power state, the block raises the clock-enable, emits a one-cycle exit pulse and returns to active. The transaction is only passed on once the rank is active. Entry and exit pulses tell the command path when to issue the matching commands. A DLL-off flag marks power-down in the DLL-off modes. The command encoding and the DLL itself lie outside this block.

Top module: `rank_lp_ctrl`

## Requirements
- R1: After reset the power state is active (code 0), `cke` is 1, and `dll_off`, `enter_pulse` and `exit_pulse` are 0.
- R2: With mode 1, 2, 3, 6 or 7, the state becomes power-down (code 1, `cke` 0) in the cycle after the clock edge that samples the N-th consecutive cycle with `txn_pending` low, where N is `pd_idle_cycles`, or 1 when that value is 0.
- R3: Mode codes 0, 4 and 5 never cause power-down entry, however long the rank stays idle.
- R4: With `sr_enable` high, the state becomes self-refresh (code 2, `cke` 0) in the cycle after the edge that samples the M-th consecutive idle cycle, where M is `sr_idle_cycles`, or 1 when that value is 0. This holds from both active and power-down.
- R5: With `sr_enable` low, a rank that is not already in self-refresh never enters it.
- R6: When the power-down and self-refresh thresholds are both met at the same edge, the rank enters self-refresh.
- R7: A cycle with `txn_pending` high restarts both idle counts, so an idle run broken by one busy cycle does not reach either threshold.
- R8: A pending transaction in power-down or self-refresh returns the state to active in the next cycle, with `cke` 1 and `exit_pulse` high for exactly that one cycle.
- R9: `enter_pulse` is high for exactly the first cycle of every entry into power-down or self-refresh, including the step from power-down to self-refresh.
- R10: `dll_off` is 1 only while the state is power-down and the mode is 6 or 7.
- R11: `txn_go` equals `txn_pending` while the state is active and is 0 otherwise. The rank never leaves active at an edge that samples `txn_pending` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_pending | input | 1 | A transaction for this rank is waiting |
| pd_mode | input | 3 | Power-down mode (0 none, 1 active, 2 precharge, 3 both, 6 precharge with DLL off, 7 all; 4 and 5 act as none) |
| pd_idle_cycles | input | 8 | Idle cycles before power-down; should cover the worst round trip plus burst length |
| sr_enable | input | 1 | Allows self-refresh entry |
| sr_idle_cycles | input | 16 | Idle cycles before self-refresh |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| cke | output | 1 | Clock enable to the rank, low in any low-power state |
| dll_off | output | 1 | Power-down with DLL off is in effect |
| enter_pulse | output | 1 | One-cycle pulse on entry to a low-power state |
| exit_pulse | output | 1 | One-cycle pulse on return to active |
| txn_go | output | 1 | Pending transaction may proceed |

## Verification
On every cycle the assertions check the local rules: a pending request in a low-power state forces active with an exit pulse, no entry happens while a request is pending, the disabled modes and a cleared self-refresh enable block their entries, the DLL-off flag stays inside power-down, and the two pulses never coincide. Exact idle-count timing needs a reference model. That covers the entry cycle for a given threshold, the restart of both counts after a busy cycle, the zero-threshold case, the choice of self-refresh when both thresholds expire together, and the later step from power-down into self-refresh. Only the bench shows these, by comparing every output each cycle against its own model under random and directed traffic.

// File: rtl/rank_lp_pkg.sv
package rank_lp_pkg;

  localparam int unsigned CNT_W_MAX = 16;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_PDOWN  = 2'd1,
    PS_SREF   = 2'd2
  } pwr_state_e;

  // Modes that request some form of power-down; 4 and 5 behave as none.
  function automatic logic mode_allows_pd(input logic [2:0] mode);
    case (mode)
      3'd1, 3'd2, 3'd3, 3'd6, 3'd7: mode_allows_pd = 1'b1;
      default:                      mode_allows_pd = 1'b0;
    endcase
  endfunction

  function automatic logic mode_drops_dll(input logic [2:0] mode);
    mode_drops_dll = (mode == 3'd6) || (mode == 3'd7);
  endfunction

  // True when this idle cycle (counted cycles plus the current one)
  // reaches the threshold; a zero threshold acts as one.
  function automatic logic idle_reached(input logic [CNT_W_MAX-1:0] counted,
                                        input logic [CNT_W_MAX-1:0] thresh);
    logic [CNT_W_MAX:0] run;
    logic [CNT_W_MAX:0] lim;
    run = {1'b0, counted} + {{CNT_W_MAX{1'b0}}, 1'b1};
    lim = (thresh == '0) ? {{CNT_W_MAX{1'b0}}, 1'b1} : {1'b0, thresh};
    idle_reached = (run >= lim);
  endfunction

endpackage

// File: rtl/rank_idle_counter.sv
module rank_idle_counter
  import rank_lp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic [W-1:0] thresh,
  output logic         hit
);

  logic [W-1:0]         cnt_q;
  logic [CNT_W_MAX-1:0] cnt_ext;
  logic [CNT_W_MAX-1:0] thr_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= '0;
    end else if (cnt_q != {W{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    cnt_ext = '0;
    thr_ext = '0;
    cnt_ext[W-1:0] = cnt_q;
    thr_ext[W-1:0] = thresh;
    hit = !busy && idle_reached(cnt_ext, thr_ext);
  end

endmodule

// File: rtl/rank_lp_fsm.sv
module rank_lp_fsm
  import rank_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       pd_hit,
  input  logic       sr_hit,
  output pwr_state_e state,
  output logic       enter_pulse,
  output logic       exit_pulse
);

  pwr_state_e state_q, state_d;
  logic       ent_q, ext_q;

  always_comb begin
    state_d = state_q;
    if (busy) begin
      state_d = PS_ACTIVE;
    end else begin
      case (state_q)
        PS_ACTIVE: begin
          if (sr_hit)      state_d = PS_SREF;
          else if (pd_hit) state_d = PS_PDOWN;
        end
        PS_PDOWN: begin
          if (sr_hit) state_d = PS_SREF;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_ACTIVE;
      ent_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ent_q   <= (state_d != PS_ACTIVE) && (state_d != state_q);
      ext_q   <= (state_d == PS_ACTIVE) && (state_q != PS_ACTIVE);
    end
  end

  assign state       = state_q;
  assign enter_pulse = ent_q;
  assign exit_pulse  = ext_q;

endmodule

// File: rtl/rank_lp_ctrl.sv
module rank_lp_ctrl
  import rank_lp_pkg::*;
#(
  parameter int unsigned PD_W = 8,
  parameter int unsigned SR_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            txn_pending,
  input  logic [2:0]      pd_mode,
  input  logic [PD_W-1:0] pd_idle_cycles,
  input  logic            sr_enable,
  input  logic [SR_W-1:0] sr_idle_cycles,
  output logic [1:0]      pwr_state,
  output logic            cke,
  output logic            dll_off,
  output logic            enter_pulse,
  output logic            exit_pulse,
  output logic            txn_go
);

  // Named internal events, visible to the bound checker.
  logic       pd_cnt_hit;
  logic       sr_cnt_hit;
  logic       pd_hit;
  logic       sr_hit;
  pwr_state_e state;

  rank_idle_counter #(.W(PD_W)) u_pd_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (txn_pending),
    .thresh (pd_idle_cycles),
    .hit    (pd_cnt_hit)
  );

  rank_idle_counter #(.W(SR_W)) u_sr_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (txn_pending),
    .thresh (sr_idle_cycles),
    .hit    (sr_cnt_hit)
  );

  assign pd_hit = pd_cnt_hit && mode_allows_pd(pd_mode);
  assign sr_hit = sr_cnt_hit && sr_enable;

  rank_lp_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (txn_pending),
    .pd_hit      (pd_hit),
    .sr_hit      (sr_hit),
    .state       (state),
    .enter_pulse (enter_pulse),
    .exit_pulse  (exit_pulse)
  );

  assign pwr_state = state;
  assign cke       = (state == PS_ACTIVE);
  assign dll_off   = (state == PS_PDOWN) && mode_drops_dll(pd_mode);
  assign txn_go    = txn_pending && (state == PS_ACTIVE);

endmodule

// File: rtl/rank_lp_chk.sv
module rank_lp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_pending,
  input logic [2:0] pd_mode,
  input logic       sr_enable,
  input logic [1:0] pwr_state,
  input logic       cke,
  input logic       dll_off,
  input logic       enter_pulse,
  input logic       exit_pulse,
  input logic       txn_go
);

  // R8: a request in a low-power state brings the rank back with an exit pulse
  assert_wake_on_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_pending && pwr_state != 2'd0) |=> (pwr_state == 2'd0 && cke && exit_pulse));

  // R11: no entry while a request is pending
  assert_no_entry_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_pending && pwr_state == 2'd0) |=> (pwr_state == 2'd0 && !enter_pulse));

  // R3: disabled modes never reach power-down from active
  assert_mode_blocks_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && (pd_mode == 3'd0 || pd_mode == 3'd4 || pd_mode == 3'd5))
      |=> (pwr_state != 2'd1));

  // R5: self-refresh not entered while disabled
  assert_sr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_enable && pwr_state != 2'd2) |=> (pwr_state != 2'd2));

  // R10: DLL-off flag only inside power-down
  assert_dll_only_in_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off |-> (pwr_state == 2'd1));

  // R9: entry pulse marks a change into a low-power state
  assert_enter_marks_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |-> (pwr_state != 2'd0 && pwr_state != $past(pwr_state)));

  // R8 / R9: pulses never coincide
  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_pulse, exit_pulse}));

  // R11: no go signal outside active
  assert_go_only_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_go |-> cke);

endmodule

bind rank_lp_ctrl rank_lp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txn_pending (txn_pending),
  .pd_mode     (pd_mode),
  .sr_enable   (sr_enable),
  .pwr_state   (pwr_state),
  .cke         (cke),
  .dll_off     (dll_off),
  .enter_pulse (enter_pulse),
  .exit_pulse  (exit_pulse),
  .txn_go      (txn_go)
);

// File: tb/tb_rank_lp_ctrl.sv
`timescale 1ns/1ps
module tb_rank_lp_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_pending = 1'b1;
  logic [2:0]  pd_mode = 3'd0;
  logic [7:0]  pd_idle_cycles = 8'd0;
  logic        sr_enable = 1'b0;
  logic [15:0] sr_idle_cycles = 16'd0;
  logic [1:0]  pwr_state;
  logic        cke, dll_off, enter_pulse, exit_pulse, txn_go;

  always #4 clk = ~clk;

  rank_lp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .txn_pending(txn_pending), .pd_mode(pd_mode),
    .pd_idle_cycles(pd_idle_cycles), .sr_enable(sr_enable),
    .sr_idle_cycles(sr_idle_cycles), .pwr_state(pwr_state), .cke(cke),
    .dll_off(dll_off), .enter_pulse(enter_pulse), .exit_pulse(exit_pulse),
    .txn_go(txn_go)
  );

  int n_checks = 0;
  int n_errors = 0;

  // Reference model state
  int m_st  = 0;
  int m_run = 0;
  bit m_ent = 0;
  bit m_ext = 0;

  function automatic bit pd_mode_on(input int md);
    return !(md == 0 || md == 4 || md == 5);
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int nst;
    bit sr_ok, pd_ok;
    nst = m_st;
    if (txn_pending) begin
      m_run = 0;
      nst = 0;
    end else begin
      m_run++;
      sr_ok = sr_enable && (m_run >= at_least_one(int'(sr_idle_cycles)));
      pd_ok = pd_mode_on(int'(pd_mode)) && (m_run >= at_least_one(int'(pd_idle_cycles)));
      if (m_st == 0) nst = sr_ok ? 2 : (pd_ok ? 1 : 0);
      else if (m_st == 1 && sr_ok) nst = 2;
    end
    m_ent = (nst != 0) && (nst != m_st);
    m_ext = (nst == 0) && (m_st != 0);
    m_st = nst;
  endtask

  task automatic compare_all();
    chk("R2/R4 pwr_state", int'(pwr_state), m_st);
    chk("R8 cke", int'(cke), (m_st == 0) ? 1 : 0);
    chk("R9 enter_pulse", int'(enter_pulse), int'(m_ent));
    chk("R8 exit_pulse", int'(exit_pulse), int'(m_ext));
    chk("R10 dll_off", int'(dll_off),
        (m_st == 1 && (pd_mode == 3'd6 || pd_mode == 3'd7)) ? 1 : 0);
    chk("R11 txn_go", int'(txn_go), (txn_pending && m_st == 0) ? 1 : 0);
  endtask

  // One clock: model follows the inputs held across the edge, then compare.
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    txn_pending = 1'b0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic busy(input int n);
    txn_pending = 1'b1;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic cfg(input int md, input int pdt, input bit sre, input int srt);
    pd_mode = 3'(md);
    pd_idle_cycles = 8'(pdt);
    sr_enable = sre;
    sr_idle_cycles = 16'(srt);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1 state", int'(pwr_state), 0);
    chk("R1 cke", int'(cke), 1);
    chk("R1 dll_off", int'(dll_off), 0);
    chk("R1 pulses", int'({enter_pulse, exit_pulse}), 0);
    rst_n = 1'b1;

    // R2: power-down after exactly 5 idle cycles
    cfg(2, 5, 0, 100);
    busy(1);
    idle(4);
    chk("R2 not yet", int'(pwr_state), 0);
    idle(1);
    chk("R2 entered", int'(pwr_state), 1);
    chk("R9 entry pulse", int'(enter_pulse), 1);
    // R8: wake up
    busy(1);
    chk("R8 active", int'(pwr_state), 0);
    chk("R8 exit pulse", int'(exit_pulse), 1);

    // R7: broken idle runs do not reach the threshold
    cfg(1, 5, 1, 6);
    busy(1); idle(4); busy(1); idle(4);
    chk("R7 still active", int'(pwr_state), 0);
    busy(1);

    // R3: disabled modes
    for (int k = 0; k < 3; k++) begin
      cfg((k == 0) ? 0 : k + 3, 2, 0, 0);
      busy(1); idle(30);
      chk("R3 no pd", int'(pwr_state), 0);
    end

    // R5: self-refresh disabled
    cfg(0, 1, 0, 3);
    busy(1); idle(60);
    chk("R5 no sref", int'(pwr_state), 0);

    // R6: both thresholds at once
    cfg(3, 3, 1, 3);
    busy(1); idle(3);
    chk("R6 sref wins", int'(pwr_state), 2);
    busy(1);

    // R4: power-down then self-refresh, zero threshold
    cfg(6, 0, 1, 8);
    busy(1); idle(1);
    chk("R2 zero threshold", int'(pwr_state), 1);
    chk("R10 dll off", int'(dll_off), 1);
    pd_mode = 3'd2;
    #1 chk("R10 dll follows mode", int'(dll_off), 0);
    idle(7);
    chk("R4 pd to sref", int'(pwr_state), 2);
    chk("R9 second entry", int'(enter_pulse), 1);
    busy(2);

    // R2: full 8-bit threshold
    cfg(7, 255, 0, 0);
    busy(1); idle(254);
    chk("R2 max minus one", int'(pwr_state), 0);
    idle(1);
    chk("R2 max threshold", int'(pwr_state), 1);
    busy(1);

    // Random traffic against the model
    for (int blk = 0; blk < 400; blk++) begin
      cfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 12)),
          bit'($urandom_range(0, 1)), int'($urandom_range(0, 40)));
      for (int j = 0; j < 40; j++) begin
        if ($urandom_range(0, 99) < 15) busy(int'($urandom_range(1, 3)));
        else idle(1);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule